// File: doc/BRIEF.md
# Relocatable Indexed CRT Register Port

This block is the byte-wide I/O front end of a display adapter's CRT register set. It watches a 10-bit I/O address bus. It decodes an index/data port pair for a 25-entry CRT-controller register file, a configuration (miscellaneous output) register, and a status/feature port. Bit 0 of the configuration register moves the index/data pair and the status/feature port between a monochrome base (3B0h) and a color base (3D0h). The configuration port stays fixed at 3C2h.

Writes are either single bytes or 16-bit words. A word write is split into two byte writes: the low byte goes to the given address and the high byte to the next address. At the index port, this selects a register and loads it in one bus cycle. Reads are answered one clock later with a valid flag, and only on the ports that allow reads. The register file is presented flat, for a timing generator that lies outside this block.

Top module: `vrp_regport`

## Requirements
- R1: After reset, the configuration register is 00h (monochrome base), the index is 0, every CRT register is 00h and the feature outputs are 0.
- R2: When configuration bit 0 is 0, the index, data and status/feature ports are at 3B4h, 3B5h and 3BAh. When it is 1, they are at 3D4h, 3D5h and 3DAh.
- R3: A byte write to the index port stores the index. A later byte write to the data port loads CRT register[index], which appears on `crtc_regs_o[8*index +: 8]`.
- R4: A word write at the index port stores the low byte as the index. In the same cycle, it loads the high byte into the register that the new index selects.
- R5: A read of the data port with index 0Ch..0Fh returns the stored register value, with `io_rvalid` high, on the clock edge after the one that samples `io_rd`.
- R6: A data-port read with index 10h returns `lpen_addr_i[15:8]`, and with index 11h returns `lpen_addr_i[7:0]`. Writes to those indices load the register file instead. Index 11h keeps only bits 3:0, and bits 7:4 stay 0.
- R7: Reads of the index port or the status/feature port give `io_rvalid`=0 and `io_rdata`=00h. Data-port reads of write-only indices (00h..0Bh, 12h..18h) give valid 00h.
- R8: A write to 3C2h loads the configuration register. A read of 3C2h returns {irq_pend_i, feat_in_i[1], feat_in_i[0], sw_sense_i, 4'b0000} with valid.
- R9: A write to the active status/feature port drives data bits 1:0 onto `feat_ctl_q`.
- R10: Accesses to the inactive base's ports change no state. Reads of them give `io_rvalid`=0 and `io_rdata`=00h.
- R11: An index of 19h or higher selects nothing. Data-port writes are dropped, and data-port reads return valid 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | With io_wr: 16-bit write split into two bytes |
| io_wdata | input | 16 | Write data; the low byte is used alone for byte writes |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, registered |
| io_rvalid | output | 1 | Read data valid, one cycle after io_rd |
| sw_sense_i | input | 1 | Configuration switch sense |
| feat_in_i | input | 2 | Feature input pins |
| irq_pend_i | input | 1 | CRT interrupt pending |
| lpen_addr_i | input | 16 | Latched light-pen address |
| misc_q | output | 8 | Configuration register |
| feat_ctl_q | output | 2 | Feature control outputs |
| crtc_regs_o | output | 200 | CRT register file, register i at bits 8*i+7..8*i |

## Verification
The bench mixes directed sequences with seeded random traffic across both bases' ports, the fixed configuration port and the two neighbouring addresses, using byte and word writes.

The directed cases pick out specific behaviour:
- Ports at the wrong base are compared with the active ones, which shows whether relocation follows configuration bit 0.
- Indices 10h and 11h are used with differing light-pen and written values, which separates the read path from the write path.
- Indices 0Bh/0Ch and 0Fh/10h sit on the edges of the readable window.
- Indices 18h/19h test the end of the register file.
- Word writes at the index port, at the data port and at the address just below the index port show whether the split puts each byte at the right port.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int ADDR_W = 10;
  typedef logic [ADDR_W-1:0] io_addr_t;

  localparam io_addr_t MONO_BASE  = 10'h3B0;
  localparam io_addr_t COLOR_BASE = 10'h3D0;
  localparam io_addr_t CFG_PORT   = 10'h3C2;
  localparam logic [3:0] OFF_IDX  = 4'h4;
  localparam logic [3:0] OFF_DAT  = 4'h5;
  localparam logic [3:0] OFF_STAT = 4'hA;

  localparam logic [7:0] RB_FIRST = 8'h0C;
  localparam logic [7:0] RB_LAST  = 8'h0F;
  localparam logic [7:0] LP_HI    = 8'h10;
  localparam logic [7:0] LP_LO    = 8'h11;

  typedef struct packed {
    logic idx;
    logic dat;
    logic stat;
    logic cfg;
  } port_hit_t;

  function automatic io_addr_t port_of(input logic color, input logic [3:0] off);
    return (color ? COLOR_BASE : MONO_BASE) | io_addr_t'(off);
  endfunction

  function automatic logic [7:0] status_byte(input logic irq, input logic [1:0] feat,
                                             input logic sense);
    return {irq, feat[1], feat[0], sense, 4'b0000};
  endfunction
endpackage

// File: rtl/vrp_decode.sv
module vrp_decode
  import vrp_pkg::*;
(
  input  io_addr_t  addr,
  input  logic      color_sel,
  output port_hit_t hit
);
  always_comb begin
    hit      = '0;
    hit.idx  = (addr == port_of(color_sel, OFF_IDX));
    hit.dat  = (addr == port_of(color_sel, OFF_DAT));
    hit.stat = (addr == port_of(color_sel, OFF_STAT));
    hit.cfg  = (addr == CFG_PORT);
  end
endmodule

// File: rtl/vrp_crtc_file.sv
module vrp_crtc_file
  import vrp_pkg::*;
#(
  parameter int NREGS    = 25,
  parameter int VRE_IDX  = 17,
  parameter int VRE_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_we,
  input  logic [7:0]         idx_wd,
  input  logic               dat_we,
  input  logic [7:0]         dat_wd,
  input  logic [15:0]        lpen,
  output logic [7:0]         idx_q,
  output logic [NREGS*8-1:0] regs_flat,
  output logic [7:0]         rd_byte
);
  localparam logic [7:0] VRE_MASK = 8'((1 << VRE_BITS) - 1);

  logic [7:0] regs [NREGS];
  logic [7:0] idx_next;

  // a word write stores the index first, so its data byte follows the new index
  assign idx_next = idx_we ? idx_wd : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= idx_wd;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [7:0] KEEP = (i == VRE_IDX) ? VRE_MASK : 8'hFF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[i] <= '0;
      else if (dat_we && idx_next == 8'(i))        regs[i] <= dat_wd & KEEP;
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rd_byte = 8'h00;
    if (idx_q >= RB_FIRST && idx_q <= RB_LAST) rd_byte = regs[idx_q[4:0]];
    else if (idx_q == LP_HI)                   rd_byte = lpen[15:8];
    else if (idx_q == LP_LO)                   rd_byte = lpen[7:0];
  end
endmodule

// File: rtl/vrp_regport.sv
module vrp_regport
  import vrp_pkg::*;
#(
  parameter int NREGS = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [9:0]         io_addr,
  input  logic               io_wr,
  input  logic               io_wide,
  input  logic [15:0]        io_wdata,
  input  logic               io_rd,
  output logic [7:0]         io_rdata,
  output logic               io_rvalid,
  input  logic               sw_sense_i,
  input  logic [1:0]         feat_in_i,
  input  logic               irq_pend_i,
  input  logic [15:0]        lpen_addr_i,
  output logic [7:0]         misc_q,
  output logic [1:0]         feat_ctl_q,
  output logic [NREGS*8-1:0] crtc_regs_o
);
  port_hit_t  hit_lo, hit_hi;
  io_addr_t   addr_hi;
  logic       we_lo, we_hi;
  logic [7:0] b_lo, b_hi;
  logic       idx_we, dat_we, cfg_we, stat_we;
  logic [7:0] idx_wd, dat_wd, cfg_wd, stat_wd;
  logic [7:0] idx_q, crtc_rd;
  logic       rd_dat_evt, rd_cfg_evt;

  assign addr_hi = io_addr + io_addr_t'(1);
  assign b_lo    = io_wdata[7:0];
  assign b_hi    = io_wdata[15:8];
  assign we_lo   = io_wr;
  assign we_hi   = io_wr & io_wide;

  vrp_decode u_dec_lo (.addr(io_addr), .color_sel(misc_q[0]), .hit(hit_lo));
  vrp_decode u_dec_hi (.addr(addr_hi), .color_sel(misc_q[0]), .hit(hit_hi));

  // each port takes the byte whose address hit it
  assign idx_we  = (we_lo & hit_lo.idx)  | (we_hi & hit_hi.idx);
  assign idx_wd  = hit_lo.idx  ? b_lo : b_hi;
  assign dat_we  = (we_lo & hit_lo.dat)  | (we_hi & hit_hi.dat);
  assign dat_wd  = hit_lo.dat  ? b_lo : b_hi;
  assign cfg_we  = (we_lo & hit_lo.cfg)  | (we_hi & hit_hi.cfg);
  assign cfg_wd  = hit_lo.cfg  ? b_lo : b_hi;
  assign stat_we = (we_lo & hit_lo.stat) | (we_hi & hit_hi.stat);
  assign stat_wd = hit_lo.stat ? b_lo : b_hi;

  vrp_crtc_file #(.NREGS(NREGS)) u_file (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .idx_wd(idx_wd),
    .dat_we(dat_we), .dat_wd(dat_wd),
    .lpen(lpen_addr_i),
    .idx_q(idx_q), .regs_flat(crtc_regs_o), .rd_byte(crtc_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      misc_q     <= '0;
      feat_ctl_q <= '0;
    end else begin
      if (cfg_we)  misc_q     <= cfg_wd;
      if (stat_we) feat_ctl_q <= stat_wd[1:0];
    end
  end

  assign rd_dat_evt = io_rd & hit_lo.dat;
  assign rd_cfg_evt = io_rd & hit_lo.cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_dat_evt | rd_cfg_evt;
      io_rdata  <= rd_dat_evt ? crtc_rd :
                   rd_cfg_evt ? status_byte(irq_pend_i, feat_in_i, sw_sense_i) : 8'h00;
    end
  end
endmodule

// File: rtl/vrp_regport_chk.sv
module vrp_regport_chk
  import vrp_pkg::*;
#(
  parameter int NREGS = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic [9:0]         io_addr,
  input logic               io_wr,
  input logic               io_rd,
  input logic [7:0]         io_rdata,
  input logic               io_rvalid,
  input logic [7:0]         misc_q,
  input logic [1:0]         feat_ctl_q,
  input logic [NREGS*8-1:0] crtc_regs_o,
  input logic               idx_we,
  input logic               dat_we
);
  localparam int VRE_POS = 17 * 8 + 4;

  p_rvalid_needs_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd));

  p_index_port_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == port_of(misc_q[0], OFF_IDX)) |=> (!io_rvalid && io_rdata == 8'h00));

  p_inactive_base_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == port_of(!misc_q[0], OFF_DAT)) |=> (!io_rvalid && io_rdata == 8'h00));

  p_status_low_nibble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == CFG_PORT) |=> (io_rvalid && io_rdata[3:0] == 4'h0));

  p_feat_moves_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(feat_ctl_q) |-> $past(io_wr));

  p_base_moves_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(misc_q[0]) |-> $past(io_wr));

  p_vre_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crtc_regs_o[VRE_POS +: 4] == 4'h0);

  p_no_write_events_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |-> (!idx_we && !dat_we));
endmodule

bind vrp_regport vrp_regport_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .io_rvalid(io_rvalid), .misc_q(misc_q),
  .feat_ctl_q(feat_ctl_q), .crtc_regs_o(crtc_regs_o),
  .idx_we(idx_we), .dat_we(dat_we)
);

// File: tb/vrp_regport_tb.sv
module vrp_regport_tb;
  localparam int NR = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic io_wr = 1'b0, io_wide = 1'b0, io_rd = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_rvalid;
  logic sw_sense_i = 1'b0, irq_pend_i = 1'b0;
  logic [1:0] feat_in_i = '0;
  logic [15:0] lpen_addr_i = '0;
  logic [7:0] misc_q;
  logic [1:0] feat_ctl_q;
  logic [NR*8-1:0] crtc_regs_o;

  always #4 clk = ~clk;

  vrp_regport #(.NREGS(NR)) u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_misc, m_idx;
  logic [7:0] m_regs [NR];
  logic [1:0] m_feat;

  function automatic logic [9:0] mbase();
    return m_misc[0] ? 10'h3D0 : 10'h3B0;
  endfunction

  function automatic void mwrite(logic [9:0] a, logic [7:0] d);
    if (a == (mbase() | 10'h4)) m_idx = d;
    else if (a == (mbase() | 10'h5)) begin
      if (m_idx < 8'(NR)) m_regs[m_idx] = (m_idx == 8'h11) ? (d & 8'h0F) : d;
    end
    else if (a == (mbase() | 10'hA)) m_feat = d[1:0];
    else if (a == 10'h3C2) m_misc = d;
  endfunction

  function automatic logic [8:0] mread(logic [9:0] a);
    if (a == (mbase() | 10'h5)) begin
      if (m_idx >= 8'h0C && m_idx <= 8'h0F) return {1'b1, m_regs[m_idx]};
      if (m_idx == 8'h10) return {1'b1, lpen_addr_i[15:8]};
      if (m_idx == 8'h11) return {1'b1, lpen_addr_i[7:0]};
      return {1'b1, 8'h00};
    end
    if (a == 10'h3C2) return {1'b1, irq_pend_i, feat_in_i, sw_sense_i, 4'h0};
    return 9'h000;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk({tag, " misc"}, 32'(misc_q), 32'(m_misc));
    chk({tag, " feat"}, 32'(feat_ctl_q), 32'(m_feat));
    for (int i = 0; i < NR; i++)
      chk({tag, " reg"}, {16'(i), 8'h0, crtc_regs_o[i*8 +: 8]}, {16'(i), 8'h0, m_regs[i]});
  endtask

  task automatic wr8(logic [9:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = {8'h00, d}; io_wr = 1'b1; io_wide = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
    mwrite(a, d);
  endtask

  task automatic wr16(logic [9:0] a, logic [15:0] w);
    @(negedge clk);
    io_addr = a; io_wdata = w; io_wr = 1'b1; io_wide = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wide = 1'b0;
    mwrite(a, w[7:0]);
    mwrite(a + 10'd1, w[15:8]);
  endtask

  task automatic rd(logic [9:0] a, string tag);
    logic [8:0] e;
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    e = mread(a);
    @(negedge clk);
    io_rd = 1'b0;
    chk({tag, " rvalid"}, 32'(io_rvalid), 32'(e[8]));
    chk({tag, " rdata"}, 32'(io_rdata), 32'(e[7:0]));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] pick [9];
    int unsigned seed;
    m_misc = 0; m_idx = 0; m_feat = 0;
    for (int i = 0; i < NR; i++) m_regs[i] = 0;
    pick = '{10'h3B4, 10'h3B5, 10'h3BA, 10'h3D4, 10'h3D5, 10'h3DA, 10'h3C2, 10'h3C3, 10'h3B3};
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset");
    chk("R1 rvalid idle", 32'(io_rvalid), 32'd0);

    // R7: write-only index 0 reads valid 00
    rd(10'h3B5, "R7 idx0 read");
    // R3/R5: index then data, read back at the edge of the window
    wr8(10'h3B4, 8'h0C); wr8(10'h3B5, 8'h5A);
    chk_state("R3 load 0C");
    rd(10'h3B5, "R5 readback 0C");
    wr8(10'h3B4, 8'h0B); wr8(10'h3B5, 8'h33);
    rd(10'h3B5, "R7 write-only 0B");
    // R10: color ports ignored while monochrome
    wr8(10'h3D4, 8'h02); wr8(10'h3D5, 8'hEE); wr8(10'h3DA, 8'h03);
    chk_state("R10 inactive writes");
    rd(10'h3D5, "R10 inactive read");
    rd(10'h3B4, "R7 index port read");
    rd(10'h3BA, "R7 status port read");
    // R4: word writes
    wr16(10'h3B4, 16'hA50F);
    chk_state("R4 word at index");
    rd(10'h3B5, "R4 readback 0F");
    wr16(10'h3B3, 16'h0D77);
    chk_state("R4 word below index");
    // R6: light pen vs retrace registers
    lpen_addr_i = 16'hC3E1;
    wr8(10'h3B4, 8'h10); wr8(10'h3B5, 8'h77);
    rd(10'h3B5, "R6 lpen high");
    wr8(10'h3B4, 8'h11); wr8(10'h3B5, 8'hFF);
    chk_state("R6 retrace end mask");
    rd(10'h3B5, "R6 lpen low");
    // R11: end of file
    wr8(10'h3B4, 8'h18); wr8(10'h3B5, 8'h9C);
    wr8(10'h3B4, 8'h19); wr8(10'h3B5, 8'h44);
    chk_state("R11 index 19 dropped");
    rd(10'h3B5, "R11 index 19 read");
    // R9: feature control
    wr8(10'h3BA, 8'hFE);
    chk_state("R9 feature bits");
    // R8/R2: configuration and relocation
    irq_pend_i = 1'b1; feat_in_i = 2'b10; sw_sense_i = 1'b1;
    rd(10'h3C2, "R8 status read");
    wr8(10'h3C2, 8'hC1);
    chk_state("R2 to color");
    wr8(10'h3B4, 8'h0E); wr8(10'h3D4, 8'h0D); wr8(10'h3D5, 8'h61);
    rd(10'h3D5, "R2 color readback");
    rd(10'h3B5, "R10 mono silent");
    wr8(10'h3DA, 8'h01);
    chk_state("R9 color feature");

    // constrained random traffic
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      logic [9:0] a;
      logic [15:0] w;
      op = $urandom % 10;
      a = pick[$urandom % 9];
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[4:0] = 5'($urandom % 26);
      lpen_addr_i = 16'($urandom);
      feat_in_i = 2'($urandom); irq_pend_i = 1'($urandom); sw_sense_i = 1'($urandom);
      if (op < 4) wr8(a, w[7:0]);
      else if (op < 6) wr16(a, w);
      else rd(a, "R3 random read");
      if (n % 10 == 0) chk_state("R3 random state");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule